// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a physical address through eight block-translation entries. Each entry is a pair of 32-bit words: an upper word holding the effective block base, a length field and two privilege-enable bits, and a lower word holding the physical block base and a two-bit protection field. Four entries serve instruction fetches and four serve data accesses. A block covers at least 128 KB. Its length field widens an address mask, so one entry can cover up to 256 MB.

A lookup is offered on a valid/ready request channel. It carries the address and three flags: instruction or data, write or read, user or supervisor. The response comes one cycle after the request is accepted, on a valid/ready response channel. It reports a miss, or a hit with the translated address and an access code: denied, read-only or read-write. The response register has one slot. While a response is waiting and the response side holds ready low, the request side shows ready low and the held response stays unchanged. Software loads the entries through a plain write port that selects an entry, a word half and the data.

Top module: `xlat_block_match`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1 and all entry words are zero, so every lookup misses until entries are written.
- R2: An instruction fetch (req_instr=1) searches only entries 0 to 3. A data access (req_instr=0) searches only entries 4 to 7.
- R3: An entry takes part in the search only if its privilege-enable bit for the current mode is set. For user mode (req_user=1) that is upper bit 0. For supervisor mode (req_user=0) that is upper bit 1.
- R4: An entry's mask is upper bits [12:2] shifted left by 17 (bits [27:17]), ORed with 0x1FFFF. The entry matches when the address and the upper word agree in every bit where the mask is 0.
- R5: On a hit, rsp_pa takes the address bits where the mask is 1 and the lower-word bits where the mask is 0.
- R6: The protection field is lower bits [1:0]. The value 00 gives code 00 (denied). The value 10 gives code 10 (read-write). The values 01 and 11 give code 01 (read-only) for a read and code 00 for a write. Code 11 is never produced.
- R7: When several enabled entries match, the one with the lowest index decides the result.
- R8: When no entry matches, the response has rsp_hit=0, rsp_code=00 and rsp_pa=0.
- R9: A request accepted on a clock edge (req_valid and req_ready both 1) gives rsp_valid=1 after that edge. rsp_valid stays 0 when nothing was accepted and no response is held.
- R10: req_ready equals (not rsp_valid) or rsp_ready. While rsp_valid=1 and rsp_ready=0, the response fields hold steady and no new request is taken.
- R11: A write with cfg_we=1 stores cfg_data into entry cfg_idx, in the upper word when cfg_hi=1 and in the lower word otherwise. A lookup accepted on the same edge as the write uses the old contents. Lookups accepted on later edges use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Entry word write enable |
| cfg_idx | input | 3 | Entry index to write |
| cfg_hi | input | 1 | 1 selects the upper word, 0 the lower word |
| cfg_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted when high together with req_valid |
| req_ea | input | 32 | Effective address |
| req_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for user mode, 0 for supervisor mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | An entry matched |
| rsp_code | output | 2 | Access code: 00 denied, 01 read-only, 10 read-write |
| rsp_pa | output | 32 | Translated physical address |

## Verification
The bench builds the block with its default parameters: four entries per side, a 32-bit address, a 17-bit minimum block offset and an 11-bit length field. With these values the smallest block (128 KB), a 2 MB block and the largest 256 MB block all occur. The same base address is mapped on both sides so that side selection can be seen. Overlapping data entries with different privilege enables show the priority rule and the mode checks together. The stall test holds the response while a second request waits, then releases both on one edge.

// File: rtl/xbm_pkg.sv
package xbm_pkg;
  typedef enum logic [1:0] {
    ACC_DENY = 2'b00,
    ACC_RO   = 2'b01,
    ACC_RW   = 2'b10
  } acc_e;

  localparam logic [1:0] PROT_NONE = 2'b00;
  localparam logic [1:0] PROT_RW   = 2'b10;

  function automatic acc_e decode_prot(input logic [1:0] prot, input logic is_write);
    acc_e r;
    case (prot)
      PROT_NONE: r = ACC_DENY;
      PROT_RW:   r = ACC_RW;
      default:   r = is_write ? ACC_DENY : ACC_RO;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/xbm_entry_store.sv
module xbm_entry_store #(
  parameter int NENT   = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(NENT)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 idx,
  input  logic                             hi_sel,
  input  logic [ADDR_W-1:0]                data,
  output logic [NENT-1:0][ADDR_W-1:0]      upper_q,
  output logic [NENT-1:0][ADDR_W-1:0]      lower_q
);
  for (genvar g = 0; g < NENT; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        upper_q[g] <= '0;
        lower_q[g] <= '0;
      end else if (we && idx == IDX_W'(g)) begin
        if (hi_sel) upper_q[g] <= data;
        else        lower_q[g] <= data;
      end
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ($past(hi_sel) ? upper_q[$past(idx)] : lower_q[$past(idx)]) == $past(data)); // R11
endmodule

// File: rtl/xbm_entry_cmp.sv
module xbm_entry_cmp #(
  parameter int ADDR_W       = 32,
  parameter int MIN_BLK_BITS = 17,
  parameter int LEN_W        = 11,
  parameter int LEN_LSB      = 2
) (
  input  logic              side_en,
  input  logic              user,
  input  logic [ADDR_W-1:0] ea,
  input  logic [ADDR_W-1:0] upper,
  input  logic [ADDR_W-1:0] lower,
  output logic              hit,
  output logic [ADDR_W-1:0] pa,
  output logic [1:0]        prot
);
  localparam int PAD = ADDR_W - MIN_BLK_BITS - LEN_W;

  logic [ADDR_W-1:0] mask;
  logic              mode_ok;

  always_comb begin
    mask    = {{PAD{1'b0}}, upper[LEN_LSB+LEN_W-1:LEN_LSB], {MIN_BLK_BITS{1'b1}}};
    mode_ok = user ? upper[0] : upper[1];
    hit     = side_en && mode_ok && (((ea ^ upper) & ~mask) == '0);
    pa      = (ea & mask) | (lower & ~mask);
    prot    = lower[1:0];
  end
endmodule

// File: rtl/xbm_resolve.sv
module xbm_resolve
  import xbm_pkg::*;
#(
  parameter int NENT   = 8,
  parameter int ADDR_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         chk_en,
  input  logic                         is_write,
  input  logic [NENT-1:0]              hits,
  input  logic [NENT-1:0][ADDR_W-1:0]  pas,
  input  logic [NENT-1:0][1:0]         prots,
  output logic                         any_hit,
  output acc_e                         code,
  output logic [ADDR_W-1:0]            pa
);
  always_comb begin
    any_hit = 1'b0;
    code    = ACC_DENY;
    pa      = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any_hit = 1'b1;
        code    = decode_prot(prots[i], is_write);
        pa      = pas[i];
      end
    end
  end

  AST_WRITE_NEVER_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && is_write) |-> code != ACC_RO); // R6
endmodule

// File: rtl/xlat_block_match.sv
module xlat_block_match
  import xbm_pkg::*;
#(
  parameter int NUM_PER_SIDE = 4,
  parameter int ADDR_W       = 32,
  parameter int MIN_BLK_BITS = 17,
  parameter int LEN_W        = 11,
  parameter int LEN_LSB      = 2,
  localparam int NENT        = 2 * NUM_PER_SIDE,
  localparam int IDX_W       = $clog2(NENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_hi,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic              req_instr,
  input  logic              req_write,
  input  logic              req_user,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_pa
);
  logic [NENT-1:0][ADDR_W-1:0] upper_q, lower_q, ent_pa;
  logic [NENT-1:0][1:0]        ent_prot;
  logic [NENT-1:0]             ent_hit;
  logic                        sel_hit;
  acc_e                        sel_code;
  logic [ADDR_W-1:0]           sel_pa;
  logic                        take;

  xbm_entry_store #(.NENT(NENT), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .hi_sel(cfg_hi),
    .data(cfg_data), .upper_q(upper_q), .lower_q(lower_q)
  );

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    localparam bit INSTR_SIDE = (g < NUM_PER_SIDE);
    logic side_en;
    assign side_en = INSTR_SIDE ? req_instr : !req_instr;
    xbm_entry_cmp #(
      .ADDR_W(ADDR_W), .MIN_BLK_BITS(MIN_BLK_BITS), .LEN_W(LEN_W), .LEN_LSB(LEN_LSB)
    ) u_cmp (
      .side_en(side_en), .user(req_user), .ea(req_ea),
      .upper(upper_q[g]), .lower(lower_q[g]),
      .hit(ent_hit[g]), .pa(ent_pa[g]), .prot(ent_prot[g])
    );
  end

  xbm_resolve #(.NENT(NENT), .ADDR_W(ADDR_W)) u_res (
    .clk(clk), .rst_n(rst_n), .chk_en(req_valid), .is_write(req_write),
    .hits(ent_hit), .pas(ent_pa), .prots(ent_prot),
    .any_hit(sel_hit), .code(sel_code), .pa(sel_pa)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_code  <= 2'b00;
      rsp_pa    <= '0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (take) begin
        rsp_hit  <= sel_hit;
        rsp_code <= sel_code;
        rsp_pa   <= sel_pa;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !(rsp_valid && !rsp_ready)) |=> !rsp_valid); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_code) && $stable(rsp_pa)); // R10
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_code == 2'b00 && rsp_pa == '0)); // R8
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_code != 2'b11); // R6
endmodule

// File: tb/xlat_block_match_test.sv
`timescale 1ns/1ps
module xlat_block_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic        cfg_hi = 1'b0;
  logic [31:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic        req_instr = 1'b0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_pa;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  xlat_block_match uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_hi(cfg_hi),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
    .req_instr(req_instr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_code(rsp_code), .rsp_pa(rsp_pa)
  );

  // {req tag, ea, instr, write, user, exp hit, exp code, exp pa}
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {4'd7, 32'h0001_2345, 1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 32'h1001_2345}, // R7 entry0 over entry1
    {4'd3, 32'h0001_2345, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 32'h2001_2345}, // R3 user skips entry0
    {4'd4, 32'h0123_4567, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 32'h2123_4567}, // R4 256MB block
    {4'd6, 32'h0123_4567, 1'b1, 1'b1, 1'b0, 1'b1, 2'b00, 32'h2123_4567}, // R6 RO write denied
    {4'd8, 32'h1000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0000_0000}, // R8 miss
    {4'd2, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 1'b1, 2'b10, 32'h7000_1234}, // R2 data side entry7
    {4'd5, 32'h801F_FFFC, 1'b0, 1'b0, 1'b1, 1'b1, 2'b01, 32'h005F_FFFC}, // R5 2MB block
    {4'd6, 32'h801F_FFFC, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 32'h005F_FFFC}, // R6 prot 11 write
    {4'd3, 32'h8020_0000, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h0000_0000}, // R3 entry5 user-disabled
    {4'd4, 32'h8020_0000, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 32'h4020_0000}, // R4 entry5 sup
    {4'd7, 32'h801F_FFFC, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 32'h005F_FFFC}, // R7 entry4 wins over 5
    {4'd6, 32'hC001_0010, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 32'h0007_0010}, // R6 prot none
    {4'd2, 32'hC001_0010, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 32'h0000_0000}, // R2 instr side misses
    {4'd3, 32'h0000_1234, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 32'h7000_1234}  // R3 user enabled
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] idx, input bit hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_hi = hi; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] ea, input bit instr, input bit wr, input bit user);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_instr = instr; req_write = wr; req_user = user;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_rsp(input string req, input bit eh, input logic [1:0] ec, input logic [31:0] ep);
    check(rsp_valid == 1'b1, req, {31'b0, rsp_valid}, 32'd1);
    check(rsp_hit == eh, req, {31'b0, rsp_hit}, {31'b0, eh});
    check(rsp_code == ec, req, {30'b0, rsp_code}, {30'b0, ec});
    check(rsp_pa == ep, req, rsp_pa, ep);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0, "R1", {31'b0, rsp_valid}, 32'd0);
    check(req_ready == 1'b1, "R1", {31'b0, req_ready}, 32'd1);
    lookup(32'h0000_1234, 1'b0, 1'b0, 1'b0);
    check_rsp("R1", 1'b0, 2'b00, 32'h0);
    @(negedge clk);
    // R9 no request -> no response
    check(rsp_valid == 1'b0, "R9", {31'b0, rsp_valid}, 32'd0);

    cfg_write(3'd0, 1'b1, 32'h0000_0002); cfg_write(3'd0, 1'b0, 32'h1000_0002);
    cfg_write(3'd1, 1'b1, 32'h0000_1FFF); cfg_write(3'd1, 1'b0, 32'h2000_0001);
    cfg_write(3'd4, 1'b1, 32'h8000_003F); cfg_write(3'd4, 1'b0, 32'h0040_0003);
    cfg_write(3'd5, 1'b1, 32'h8000_1FFE); cfg_write(3'd5, 1'b0, 32'h4000_0002);
    cfg_write(3'd6, 1'b1, 32'hC000_0003); cfg_write(3'd6, 1'b0, 32'h0006_0000);
    cfg_write(3'd7, 1'b1, 32'h0000_0003); cfg_write(3'd7, 1'b0, 32'h7000_0002);

    for (int i = 0; i < NV; i++) begin
      logic [73:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[73:70], i);
      lookup(v[69:38], v[37], v[36], v[35]);
      check_rsp(tag, v[34], v[33:32], v[31:0]);
    end

    // R11 lower word first, then upper write on the same edge as a lookup
    cfg_write(3'd2, 1'b0, 32'h6000_0002);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd2; cfg_hi = 1'b1; cfg_data = 32'h5000_0002;
    req_valid = 1'b1; req_ea = 32'h5000_0010; req_instr = 1'b1; req_write = 1'b0; req_user = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check_rsp("R11 same-edge old", 1'b0, 2'b00, 32'h0);
    lookup(32'h5000_0010, 1'b1, 1'b0, 1'b0);
    check_rsp("R11 new contents", 1'b1, 2'b10, 32'h6000_0010);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h0001_2345; req_instr = 1'b1; req_write = 1'b0; req_user = 1'b0;
    @(negedge clk);
    check_rsp("R10 first", 1'b1, 2'b10, 32'h1001_2345);
    check(req_ready == 1'b0, "R10", {31'b0, req_ready}, 32'd0);
    req_ea = 32'h0000_1234; req_instr = 1'b0;
    @(negedge clk);
    check_rsp("R10 held", 1'b1, 2'b10, 32'h1001_2345);
    check(req_ready == 1'b0, "R10", {31'b0, req_ready}, 32'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R10 second", 1'b1, 2'b10, 32'h7000_1234);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 drained", {31'b0, rsp_valid}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule